// File: doc/BRIEF.md
# Descriptor Ring Transaction Sequencer

This block walks a circular ring of 16-byte transaction descriptors held in system memory. Software fills descriptors, then moves a head index and sets a run bit in the control register. The engine reads each descriptor from its own tail index up to that head over a 32-bit memory port. It passes the descriptor to a downstream transaction executor and waits for the result. It then writes the result status and the two byte counts back into the descriptor and steps the tail. Software sees the tail, a busy bit and two sticky interrupt flags in the status register, and clears a flag by writing a one to it.

The ring base is a 64-bit, 16-byte-aligned address. A ring-size register holds the entry count minus one, and the tail returns to zero after the entry whose index equals that value. Each descriptor carries its own request for a completion interrupt and its own request to halt the engine if that descriptor fails.

Top module: `dring_engine`

## Requirements
- R1: After reset every register reads zero, `irq` is low and no memory request or executor start is issued.
- R2: A descriptor is fetched as four 32-bit reads, one after another, at base + 16*tail + 4*k for k = 0, 1, 2, 3; a request is held with a stable address until `mem_ack`.
- R3: The tail steps by one per finished descriptor and goes to 0 after the entry whose index equals the ring-size value (ring-size register, offset 4, bits 7:0).
- R4: With the run bit (control register, offset 2, bit 0) set, descriptors are processed until tail equals head (control bits 23:16); the busy bit (status register, offset 3, bit 0) then reads 0. With the run bit clear nothing is fetched.
- R5: Each fetched descriptor appears on `exec_desc` (word k on bits 32k+31:32k) with a single-cycle `exec_start`; the engine waits for `exec_done` before going on.
- R6: The result is written back by one 32-bit write at base + 16*tail + 4 with byte strobe 4'b1101: status in byte 0, received count in byte 2, sent count in byte 3; the retry byte (byte 1) and words 0, 2, 3 stay unchanged.
- R7: A descriptor with control bit 6 (word 0 bit 30) sets the done flag (status bit 5) on completion, and `irq` goes high; a descriptor without it leaves the flag alone.
- R8: A result whose status bit 0 (success) is clear is an error; it sets the error flag (status bit 4) only when the error-interrupt enable (control bit 4) is set.
- R9: A failed descriptor with control bit 7 (word 0 bit 31) halts the engine: it is still written back, the tail stays on it and the run bit clears. A successful descriptor with bit 7 set does not halt.
- R10: Writing a one to status bit 4 or 5 clears that flag; writing zero has no effect and the tail field (status bits 23:16) cannot be written.
- R11: Registers read back as: offset 0 base bits 31:0, offset 1 base bits 63:32, offset 2 control (bits 0, 4, 23:16 only), offset 3 status, offset 4 ring size (bits 7:0 only); `irq` is the OR of the two flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 64 | Byte address of the 32-bit word |
| mem_wstrb | output | 4 | Byte write strobes |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access done; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| exec_start | output | 1 | One-cycle start pulse to the executor |
| exec_desc | output | 128 | Descriptor handed to the executor |
| exec_done | input | 1 | Executor finished |
| exec_status | input | 8 | Result status byte |
| exec_rx_cnt | input | 8 | Bytes received |
| exec_tx_cnt | input | 8 | Bytes sent |
| irq | output | 1 | Done or error flag pending |

## Verification
The bench sweeps ring sizes of 2, 3, 5, 8 and 16 entries with batches that fill the ring to one short of full and then wrap; a design that wrapped at the entry count instead of at the programmed value, or that stopped one entry early, leaves the tail and the access log wrong. Write-back is checked byte by byte, so a full-word write that clobbers the retry byte or a wrong strobe shows up in memory. The stop-on-error case fails the middle of three descriptors and expects exactly two write-backs, the tail parked on the failure and the run bit dropped; it also gives the first descriptor the halt request with a success result, which a design that ignored the status would stop on. The flag tests write zero and the tail field to the status register and expect no change, and raise an error with the enable off.

// File: rtl/dring_pkg.sv
package dring_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_EXEC,
    ST_WAIT,
    ST_WB,
    ST_ADV
  } seq_state_t;

  localparam logic [2:0] A_BASE_LO = 3'd0;
  localparam logic [2:0] A_BASE_HI = 3'd1;
  localparam logic [2:0] A_CTRL    = 3'd2;
  localparam logic [2:0] A_STAT    = 3'd3;
  localparam logic [2:0] A_SIZE    = 3'd4;

  localparam int CTL_RUN   = 0;
  localparam int CTL_ERRIE = 4;
  localparam int STA_BUSY  = 0;
  localparam int STA_ERR   = 4;
  localparam int STA_DONE  = 5;
  localparam int PTR_LSB   = 16;

  localparam int DSC_IRQ_BIT  = 30;
  localparam int DSC_HALT_BIT = 31;
  localparam int RES_OK_BIT   = 0;

  localparam int          DESC_WORDS = 4;
  localparam logic [3:0]  WB_STRB    = 4'b1101;

endpackage

// File: rtl/dring_regs.sv
module dring_regs
  import dring_pkg::*;
#(
  parameter int PTR_W = 8,
  parameter int AW    = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             ev_done,
  input  logic             ev_err,
  input  logic             ev_halt,
  input  logic [PTR_W-1:0] tail,
  input  logic             busy,
  output logic             run,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] size,
  output logic [AW-1:0]    base,
  output logic             irq
);
  localparam int HI_W = AW - 32;

  logic [AW-1:0]    base_q, base_d;
  logic [PTR_W-1:0] head_q, head_d, size_q, size_d;
  logic             run_q, run_d, eie_q, eie_d;
  logic             done_q, done_d, err_q, err_d;

  always_comb begin
    base_d = base_q;
    head_d = head_q;
    size_d = size_q;
    run_d  = run_q;
    eie_d  = eie_q;
    done_d = done_q;
    err_d  = err_q;
    if (reg_wr) begin
      case (reg_addr)
        A_BASE_LO: base_d[31:0] = reg_wdata;
        A_BASE_HI: base_d[AW-1:32] = reg_wdata[HI_W-1:0];
        A_CTRL: begin
          run_d  = reg_wdata[CTL_RUN];
          eie_d  = reg_wdata[CTL_ERRIE];
          head_d = reg_wdata[PTR_LSB +: PTR_W];
        end
        A_STAT: begin
          if (reg_wdata[STA_ERR])  err_d  = 1'b0;
          if (reg_wdata[STA_DONE]) done_d = 1'b0;
        end
        A_SIZE: size_d = reg_wdata[PTR_W-1:0];
        default: ;
      endcase
    end
    if (ev_halt) run_d = 1'b0;
    if (ev_done) done_d = 1'b1;
    if (ev_err && eie_q) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      head_q <= '0;
      size_q <= '0;
      run_q  <= 1'b0;
      eie_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      base_q <= base_d;
      head_q <= head_d;
      size_q <= size_d;
      run_q  <= run_d;
      eie_q  <= eie_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_BASE_LO: reg_rdata = base_q[31:0];
      A_BASE_HI: reg_rdata[HI_W-1:0] = base_q[AW-1:32];
      A_CTRL: begin
        reg_rdata[CTL_RUN]            = run_q;
        reg_rdata[CTL_ERRIE]          = eie_q;
        reg_rdata[PTR_LSB +: PTR_W]   = head_q;
      end
      A_STAT: begin
        reg_rdata[STA_BUSY]           = busy;
        reg_rdata[STA_ERR]            = err_q;
        reg_rdata[STA_DONE]           = done_q;
        reg_rdata[PTR_LSB +: PTR_W]   = tail;
      end
      A_SIZE: reg_rdata[PTR_W-1:0] = size_q;
      default: ;
    endcase
  end

  assign run  = run_q;
  assign head = head_q;
  assign size = size_q;
  assign base = base_q;
  assign irq  = done_q | err_q;

endmodule

// File: rtl/dring_seq.sv
module dring_seq
  import dring_pkg::*;
#(
  parameter int PTR_W = 8,
  parameter int AW    = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic [PTR_W-1:0]         head,
  input  logic [PTR_W-1:0]         size,
  input  logic [AW-1:0]            base,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [AW-1:0]            mem_addr,
  output logic [3:0]               mem_wstrb,
  output logic [31:0]              mem_wdata,
  input  logic                     mem_ack,
  input  logic [31:0]              mem_rdata,
  output logic                     exec_start,
  output logic [32*DESC_WORDS-1:0] exec_desc,
  input  logic                     exec_done,
  input  logic [7:0]               exec_status,
  input  logic [7:0]               exec_rx_cnt,
  input  logic [7:0]               exec_tx_cnt,
  output logic [PTR_W-1:0]         tail,
  output logic                     busy,
  output logic                     ev_done,
  output logic                     ev_err,
  output logic                     ev_halt
);
  localparam int WI_W = $clog2(DESC_WORDS);
  localparam logic [WI_W-1:0] WI_LAST = WI_W'(DESC_WORDS - 1);

  seq_state_t                  state_q, state_d;
  logic [WI_W-1:0]             widx_q, widx_d;
  logic [PTR_W-1:0]            tail_q, tail_d, tail_inc;
  logic [DESC_WORDS-1:0][31:0] desc_q;
  logic                        desc_we;
  logic [23:0]                 res_q;
  logic                        res_we;
  logic [AW-1:0]               entry_addr;
  logic                        failed;

  assign entry_addr = base + (AW'(tail_q) << 4);
  assign tail_inc   = (tail_q >= size) ? '0 : tail_q + 1'b1;
  assign failed     = !res_q[RES_OK_BIT];

  always_comb begin
    state_d = state_q;
    widx_d  = widx_q;
    tail_d  = tail_q;
    desc_we = 1'b0;
    res_we  = 1'b0;
    ev_done = 1'b0;
    ev_err  = 1'b0;
    ev_halt = 1'b0;
    case (state_q)
      ST_IDLE: begin
        widx_d = '0;
        if (run && tail_q != head) state_d = ST_FETCH;
      end
      ST_FETCH: begin
        if (mem_ack) begin
          desc_we = 1'b1;
          widx_d  = widx_q + 1'b1;
          if (widx_q == WI_LAST) state_d = ST_EXEC;
        end
      end
      ST_EXEC: state_d = ST_WAIT;
      ST_WAIT: begin
        if (exec_done) begin
          res_we  = 1'b1;
          state_d = ST_WB;
        end
      end
      ST_WB: begin
        if (mem_ack) state_d = ST_ADV;
      end
      ST_ADV: begin
        ev_done = desc_q[0][DSC_IRQ_BIT];
        ev_err  = failed;
        widx_d  = '0;
        if (failed && desc_q[0][DSC_HALT_BIT]) begin
          ev_halt = 1'b1;
          state_d = ST_IDLE;
        end else begin
          tail_d  = tail_inc;
          state_d = (run && tail_inc != head) ? ST_FETCH : ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      widx_q  <= '0;
      tail_q  <= '0;
    end else begin
      state_q <= state_d;
      widx_q  <= widx_d;
      tail_q  <= tail_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc_q <= '0;
    end else if (desc_we) begin
      desc_q[widx_q] <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (res_we) begin
      res_q <= {exec_tx_cnt, exec_rx_cnt, exec_status};
    end
  end

  always_comb begin
    mem_req   = (state_q == ST_FETCH) || (state_q == ST_WB);
    mem_we    = (state_q == ST_WB);
    mem_wstrb = mem_we ? WB_STRB : 4'b0000;
    mem_wdata = {res_q[23:16], res_q[15:8], 8'h00, res_q[7:0]};
    if (state_q == ST_WB) mem_addr = entry_addr + AW'(4);
    else                  mem_addr = entry_addr + AW'({widx_q, 2'b00});
  end

  assign exec_start = (state_q == ST_EXEC);
  assign exec_desc  = desc_q;
  assign tail       = tail_q;
  assign busy       = (state_q != ST_IDLE);

endmodule

// File: rtl/dring_engine.sv
module dring_engine
  import dring_pkg::*;
#(
  parameter int PTR_W = 8,
  parameter int AW    = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [2:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [3:0]     mem_wstrb,
  output logic [31:0]    mem_wdata,
  input  logic           mem_ack,
  input  logic [31:0]    mem_rdata,
  output logic           exec_start,
  output logic [127:0]   exec_desc,
  input  logic           exec_done,
  input  logic [7:0]     exec_status,
  input  logic [7:0]     exec_rx_cnt,
  input  logic [7:0]     exec_tx_cnt,
  output logic           irq
);
  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  logic             eng_run, seq_busy;
  logic             ev_done, ev_err, ev_halt;
  logic [PTR_W-1:0] reg_head, reg_size, seq_tail;
  logic [AW-1:0]    reg_base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  dring_regs #(.PTR_W(PTR_W), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ev_done   (ev_done),
    .ev_err    (ev_err),
    .ev_halt   (ev_halt),
    .tail      (seq_tail),
    .busy      (seq_busy),
    .run       (eng_run),
    .head      (reg_head),
    .size      (reg_size),
    .base      (reg_base),
    .irq       (irq)
  );

  dring_seq #(.PTR_W(PTR_W), .AW(AW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .run         (eng_run),
    .head        (reg_head),
    .size        (reg_size),
    .base        (reg_base),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wstrb   (mem_wstrb),
    .mem_wdata   (mem_wdata),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .exec_start  (exec_start),
    .exec_desc   (exec_desc),
    .exec_done   (exec_done),
    .exec_status (exec_status),
    .exec_rx_cnt (exec_rx_cnt),
    .exec_tx_cnt (exec_tx_cnt),
    .tail        (seq_tail),
    .busy        (seq_busy),
    .ev_done     (ev_done),
    .ev_err      (ev_err),
    .ev_halt     (ev_halt)
  );

endmodule

// File: rtl/dring_engine_chk.sv
module dring_engine_chk #(
  parameter int PTR_W = 8,
  parameter int AW    = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_ack,
  input logic [AW-1:0]    mem_addr,
  input logic [3:0]       mem_wstrb,
  input logic             exec_start,
  input logic             irq,
  input logic             busy,
  input logic [PTR_W-1:0] tail
);
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  a_r6_wb_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wstrb == 4'b1101 && mem_addr[3:0] == 4'h4);

  a_r5_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |=> !exec_start);

  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !exec_start);

  a_r3_tail_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tail) |-> (tail == $past(tail) + 1'b1) || (tail == '0));

  a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(busy));

endmodule

bind dring_engine dring_engine_chk #(.PTR_W(PTR_W), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_ack    (mem_ack),
  .mem_addr   (mem_addr),
  .mem_wstrb  (mem_wstrb),
  .exec_start (exec_start),
  .irq        (irq),
  .busy       (seq_busy),
  .tail       (seq_tail)
);

// File: tb/tb_dring_engine.sv
module tb_dring_engine;
  localparam logic [2:0]  A_BLO = 3'd0, A_BHI = 3'd1, A_CTL = 3'd2, A_STA = 3'd3, A_SZ = 3'd4;
  localparam logic [63:0] BASE  = 64'h0000_0002_0000_0200;
  localparam logic [31:0] W1_INIT = 32'hEEEE5AEE;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we, mem_ack;
  logic [63:0] mem_addr;
  logic [3:0] mem_wstrb;
  logic [31:0] mem_wdata, mem_rdata;
  logic exec_start, exec_done = 1'b0, irq;
  logic [127:0] exec_desc;
  logic [7:0] exec_status = '0, exec_rx_cnt = '0, exec_tx_cnt = '0;

  always #10 clk = ~clk;

  dring_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wstrb(mem_wstrb),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .exec_start(exec_start), .exec_desc(exec_desc), .exec_done(exec_done),
    .exec_status(exec_status), .exec_rx_cnt(exec_rx_cnt),
    .exec_tx_cnt(exec_tx_cnt), .irq(irq)
  );

  // memory model
  logic [31:0] mem [0:255];
  logic [63:0] rd_log [0:1023];
  logic [63:0] wr_log [0:1023];
  int rd_n = 0, wr_n = 0, exec_n = 0, desc_bad = 0;
  logic tb_we = 1'b0;
  logic [7:0] tb_idx = '0;
  logic [31:0] tb_dat = '0;
  logic [63:0] moff;
  logic [7:0] midx;
  assign moff = mem_addr - BASE;
  assign midx = moff[9:2];
  assign mem_rdata = mem[midx];

  always @(posedge clk or negedge rst_n)
    if (!rst_n) mem_ack <= 1'b0;
    else        mem_ack <= mem_req && !mem_ack;

  always @(posedge clk) begin
    if (tb_we) mem[tb_idx] <= tb_dat;
    if (mem_req && mem_ack) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_wstrb[b]) mem[midx][8*b +: 8] <= mem_wdata[8*b +: 8];
        wr_log[wr_n] <= mem_addr;
        wr_n <= wr_n + 1;
      end else begin
        rd_log[rd_n] <= mem_addr;
        rd_n <= rd_n + 1;
      end
    end
  end

  // executor model: result comes from word 2 of the descriptor
  initial begin
    forever begin
      @(negedge clk);
      if (exec_start) begin
        exec_n = exec_n + 1;
        for (int k = 0; k < 4; k++) begin
          logic [63:0] o;
          o = rd_log[rd_n - 4 + k] - BASE;
          if (exec_desc[32*k +: 32] !== mem[o[9:2]]) desc_bad = desc_bad + 1;
        end
        exec_status = exec_desc[71:64];
        exec_rx_cnt = exec_desc[79:72];
        exec_tx_cnt = exec_desc[87:80];
        repeat (3) @(negedge clk);
        exec_done = 1'b1;
        @(negedge clk);
        exec_done = 1'b0;
      end
    end
  end

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic poke(input int i, input logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_idx = 8'(i); tb_dat = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  function automatic logic [31:0] w0(input int e, input logic [7:0] c);
    return {c, 8'h02, 8'h01, 8'h50 | 8'(e)};
  endfunction

  task automatic fill(input int e, input logic [7:0] c, input logic [7:0] st,
                      input logic [7:0] rx, input logic [7:0] tx);
    poke(4*e,     w0(e, c));
    poke(4*e + 1, W1_INIT);
    poke(4*e + 2, {8'h00, tx, rx, st});
    poke(4*e + 3, {16'hC0DE, 8'h00, 8'(e)});
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    repeat (3) @(negedge clk);
    for (int t = 0; t < 3000; t++) begin
      rreg(A_STA, s);
      if (!s[0]) break;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int sizes [5];
    int exp_tail, head, cnt, rs, ws, es, e;
    bit okr, okw, okd;
    sizes = '{2, 3, 5, 8, 16};

    do_reset();
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rreg(3'(a), v);
      check(v == 32'h0, "R1 register reset", 64'(v), 64'h0);
    end
    check(irq == 1'b0 && mem_req == 1'b0 && exec_start == 1'b0, "R1 outputs idle",
          {61'h0, irq, mem_req, exec_start}, 64'h0);

    // ring sweep: R2 R3 R4 R5 R6
    foreach (sizes[si]) begin
      do_reset();
      wreg(A_BLO, BASE[31:0]);
      wreg(A_BHI, BASE[63:32]);
      wreg(A_SZ, 32'(sizes[si] - 1));
      exp_tail = 0;
      for (int b = 0; b < 3; b++) begin
        cnt = (b == 1) ? 1 : sizes[si] - 1;
        rs = rd_n; ws = wr_n; es = exec_n;
        okr = 1; okw = 1; okd = 1;
        for (int j = 0; j < cnt; j++)
          fill((exp_tail + j) % sizes[si], 8'h00, 8'h01, 8'(j + sizes[si]), 8'(2*j + 1));
        head = (exp_tail + cnt) % sizes[si];
        wreg(A_CTL, (32'(head) << 16) | 32'h1);
        wait_idle();
        for (int j = 0; j < cnt; j++) begin
          e = (exp_tail + j) % sizes[si];
          for (int k = 0; k < 4; k++)
            if (rd_log[rs + 4*j + k] !== BASE + 64'(16*e + 4*k)) okr = 0;
          if (wr_log[ws + j] !== BASE + 64'(16*e + 4)) okw = 0;
          if (mem[4*e + 1] !== {8'(2*j + 1), 8'(j + sizes[si]), 8'h5A, 8'h01}) okd = 0;
          if (mem[4*e] !== w0(e, 8'h00) || mem[4*e + 3] !== {16'hC0DE, 8'h00, 8'(e)}) okd = 0;
        end
        rreg(A_STA, v);
        check(v == (32'(head) << 16), "R3 tail wrap / R4 idle at head", 64'(v), 64'(head) << 16);
        check(rd_n - rs == 4*cnt, "R2 read count", 64'(rd_n - rs), 64'(4*cnt));
        check(okr, "R2 fetch addresses", 64'(okr), 64'h1);
        check(wr_n - ws == cnt && okw, "R6 write-back addresses", 64'(wr_n - ws), 64'(cnt));
        check(okd, "R6 write-back bytes", 64'(okd), 64'h1);
        check(exec_n - es == cnt, "R5 executor handoffs", 64'(exec_n - es), 64'(cnt));
        check(irq == 1'b0, "R7 no flag without request", 64'(irq), 64'h0);
        exp_tail = head;
      end
    end
    check(desc_bad == 0, "R5 exec_desc matches memory", 64'(desc_bad), 64'h0);

    // directed tests, 8-entry ring
    do_reset();
    wreg(A_BLO, BASE[31:0]);
    wreg(A_BHI, BASE[63:32]);
    wreg(A_SZ, 32'h7);

    // R4 run bit clear
    rs = rd_n;
    wreg(A_CTL, 32'h0003_0000);
    repeat (30) @(negedge clk);
    rreg(A_STA, v);
    check(rd_n == rs && v == 32'h0, "R4 no fetch with run clear", 64'(rd_n - rs), 64'h0);

    // R7 done flag, R10 clear behaviour
    fill(0, 8'h40, 8'h01, 8'h03, 8'h04);
    wreg(A_CTL, 32'h0001_0001);
    wait_idle();
    rreg(A_STA, v);
    check(v == 32'h0001_0020 && irq, "R7 done flag set", 64'(v), 64'h0001_0020);
    wreg(A_STA, 32'h0);
    rreg(A_STA, v);
    check(v == 32'h0001_0020, "R10 zero write no effect", 64'(v), 64'h0001_0020);
    wreg(A_STA, 32'h00FF_0010);
    rreg(A_STA, v);
    check(v == 32'h0001_0020, "R10 tail not writable", 64'(v), 64'h0001_0020);
    wreg(A_STA, 32'h20);
    rreg(A_STA, v);
    check(v == 32'h0001_0000 && !irq, "R10 done flag cleared", 64'(v), 64'h0001_0000);

    // R8 error with enable clear
    fill(1, 8'h00, 8'h08, 8'h00, 8'h01);
    wreg(A_CTL, 32'h0002_0001);
    wait_idle();
    rreg(A_STA, v);
    check(v == 32'h0002_0000 && !irq, "R8 error masked", 64'(v), 64'h0002_0000);
    check(mem[5] == 32'h0100_5A08, "R6 error status written", 64'(mem[5]), 64'h0100_5A08);

    // R8 error with enable set
    fill(2, 8'h00, 8'h10, 8'h00, 8'h00);
    wreg(A_CTL, 32'h0003_0011);
    wait_idle();
    rreg(A_STA, v);
    check(v == 32'h0003_0010 && irq, "R8 error flag set", 64'(v), 64'h0003_0010);
    wreg(A_STA, 32'h10);
    rreg(A_STA, v);
    check(v == 32'h0003_0000 && !irq, "R10 error flag cleared", 64'(v), 64'h0003_0000);

    // R9 stop on error
    fill(3, 8'h80, 8'h01, 8'h01, 8'h01);
    fill(4, 8'h80, 8'h40, 8'h00, 8'h02);
    fill(5, 8'h00, 8'h01, 8'h05, 8'h06);
    ws = wr_n;
    wreg(A_CTL, 32'h0006_0011);
    wait_idle();
    rreg(A_STA, v);
    check(v == 32'h0004_0010, "R9 tail parked on failure", 64'(v), 64'h0004_0010);
    rreg(A_CTL, v);
    check(v == 32'h0006_0010, "R9 run bit cleared", 64'(v), 64'h0006_0010);
    check(wr_n - ws == 2, "R9 two write-backs", 64'(wr_n - ws), 64'h2);
    check(mem[17] == 32'h0200_5A40, "R9 failing entry written", 64'(mem[17]), 64'h0200_5A40);
    check(mem[21] == W1_INIT, "R9 later entry untouched", 64'(mem[21]), 64'(W1_INIT));
    wreg(A_STA, 32'h10);
    poke(16, w0(4, 8'h00));
    poke(18, 32'h0000_0001);
    wreg(A_CTL, 32'h0006_0001);
    wait_idle();
    rreg(A_STA, v);
    check(v == 32'h0006_0000 && wr_n - ws == 4, "R9 resume to head", 64'(v), 64'h0006_0000);
    check(mem[21] == 32'h0605_5A01, "R6 resumed entry written", 64'(mem[21]), 64'h0605_5A01);

    // R11 register map
    rreg(A_BLO, v);
    check(v == BASE[31:0], "R11 base low", 64'(v), 64'(BASE[31:0]));
    rreg(A_BHI, v);
    check(v == BASE[63:32], "R11 base high", 64'(v), 64'(BASE[63:32]));
    wreg(A_SZ, 32'hFFFF_FF07);
    rreg(A_SZ, v);
    check(v == 32'h7, "R11 size field", 64'(v), 64'h7);
    wreg(A_CTL, 32'hFF06_FFEE);
    rreg(A_CTL, v);
    check(v == 32'h0006_0000, "R11 control fields", 64'(v), 64'h0006_0000);
    check(irq == 1'b0, "R11 irq is flag OR", 64'(irq), 64'h0);

    finish_run();
  end

endmodule